// File: doc/BRIEF.md
# Configuration Startup Sequencer

This block runs a programmable device from power-up up to the point where configuration loading may start. After the power-on reset it counts a time-out on a slow timer tick. The time-out is four times longer when the mode pins select a master mode, so that slower devices further down a chain can finish their own start-up. It then asks for the configuration memory to be erased. While these two phases run it pulls a wire-AND status line low, keeps the user output buffers disabled, and blocks power-down requests during the time-out.

Once the erase is acknowledged, the block waits for the external reset pin to be released. It captures the three mode pins and enters the load state. A reset held low across three ticks during loading aborts the load and goes back to the erase step. When the done/program pin goes high the device counts as configured. A later falling edge on that pin starts a reprogram through the erase step, and the mode pins are captured again.

Top module: `cfg_startup_seq`

## Requirements
- R1: While `por_n` is low, the outputs are: `state_o` = 0, `mode_o` = 000, `init_low_o` = 1, `obuf_dis_o` = 1, `pdn_inhibit_o` = 1 and `clr_req_o` = 0.
- R2: Outside the master codes, the power-up state ends on the clock edge that samples the 2^CNT_W-th tick after reset. The block then enters the erase state.
- R3: When `mode_pin_i` holds a master code (000 bit-serial, 011 byte-wide counting up, 010 byte-wide counting down) while ticks arrive, the power-up state lasts 4·2^CNT_W ticks.
- R4: `pdn_inhibit_o` is 1 only in the power-up state.
- R5: In the erase state, `clr_req_o` is 1. The block moves to the armed state on the edge that samples `clr_done_i` = 1, and stays in the erase state otherwise.
- R6: `init_low_o` is 1 in the power-up and erase states and 0 in all other states.
- R7: In the armed state the block enters the load state once the synchronised reset pin is high and `mode_pin_i` is a legal code (000, 010, 011, 101 peripheral, 111 slave). That edge copies `mode_pin_i` into `mode_o`. The reserved codes 001, 100 and 110 keep the block armed. A rise of `rst_pin_n_i` takes effect on the third clock edge.
- R8: In the load state, the block returns to the erase state on the third tick sampled while the synchronised reset pin is low. A high reset in between restarts that count.
- R9: In the load state, a high synchronised `prog_pin_i` moves the block to the configured state on the third edge after the pin rises. `obuf_dis_o` is 0 only in the configured state.
- R10: In the configured state, a falling `prog_pin_i` moves the block to the erase state on the third edge. The mode pins are captured again on the next exit from the armed state.
- R11: The `state_o` encoding is 0 power-up, 1 erase, 2 armed, 3 load and 4 configured.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| por_n | input | 1 | Asynchronous power-on reset, active low |
| tick_i | input | 1 | One-cycle pulse from the slow internal timer |
| rst_pin_n_i | input | 1 | External reset pin, active low, asynchronous |
| prog_pin_i | input | 1 | Done/program pin level, asynchronous |
| mode_pin_i | input | 3 | Mode select pins |
| clr_done_i | input | 1 | Erase-complete pulse |
| state_o | output | 3 | Sequencer state |
| mode_o | output | 3 | Captured mode code |
| init_low_o | output | 1 | 1 = pull the open-drain status line low |
| obuf_dis_o | output | 1 | User output buffers disabled |
| pdn_inhibit_o | output | 1 | Power-down requests blocked |
| clr_req_o | output | 1 | Configuration memory erase request |

## Verification
`tick_i`, `clr_done_i` and `mode_pin_i` act on the next clock edge. A change on either external pin passes through two synchroniser flops, so its effect shows up on the third edge. All outputs decode the state register and move in the same cycle as `state_o`. The bench drives inputs on falling edges. A behavioural model steps on the same rising edge as the design and is compared on every falling edge. The directed checks count sampled ticks or exact edge numbers, so each is read in the cycle its result is due: two edges after a pin change for "not yet" and three edges after for "now".

// File: rtl/cfg_startup_pkg.sv
package cfg_startup_pkg;

  typedef enum logic [2:0] {
    ST_POWERUP = 3'd0,
    ST_ERASE   = 3'd1,
    ST_ARMED   = 3'd2,
    ST_LOAD    = 3'd3,
    ST_RUN     = 3'd4
  } seq_state_e;

  localparam logic [2:0] MODE_MSER    = 3'b000;
  localparam logic [2:0] MODE_MBYTE_DN = 3'b010;
  localparam logic [2:0] MODE_MBYTE_UP = 3'b011;
  localparam logic [2:0] MODE_PERIPH  = 3'b101;
  localparam logic [2:0] MODE_SLAVE   = 3'b111;

  function automatic logic mode_is_master(input logic [2:0] code);
    return (code == MODE_MSER) || (code == MODE_MBYTE_DN) || (code == MODE_MBYTE_UP);
  endfunction

  function automatic logic mode_is_legal(input logic [2:0] code);
    return mode_is_master(code) || (code == MODE_PERIPH) || (code == MODE_SLAVE);
  endfunction

endpackage

// File: rtl/cfg_pin_sync.sv
module cfg_pin_sync #(
  parameter int   STAGES  = 2,
  parameter logic RST_VAL = 1'b0
) (
  input  logic clk,
  input  logic rst_n,
  input  logic d_i,
  output logic q_o
);

  logic [STAGES-1:0] sh_q;
  logic [STAGES-1:0] sh_d;

  always_comb begin
    sh_d = {sh_q[STAGES-2:0], d_i};
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sh_q <= {STAGES{RST_VAL}};
    end else begin
      sh_q <= sh_d;
    end
  end

  assign q_o = sh_q[STAGES-1];

endmodule

// File: rtl/cfg_init_timer.sv
module cfg_init_timer #(
  parameter int CNT_W     = 14,
  parameter int MST_SHIFT = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic run_i,
  input  logic tick_i,
  input  logic master_i,
  output logic expire_o
);

  localparam int W = CNT_W + MST_SHIFT;
  localparam logic [W-1:0] BASE_LAST = {{MST_SHIFT{1'b0}}, {CNT_W{1'b1}}};
  localparam logic [W-1:0] MST_LAST  = {W{1'b1}};

  logic [W-1:0] cnt_q;
  logic [W-1:0] cnt_d;
  logic         cnt_en;
  logic         at_last;

  always_comb begin
    at_last  = master_i ? (cnt_q == MST_LAST) : (cnt_q >= BASE_LAST);
    expire_o = run_i & tick_i & at_last;
    cnt_en   = ~run_i | tick_i;
    cnt_d    = cnt_q;
    if (!run_i) begin
      cnt_d = '0;
    end else if (tick_i && !at_last) begin
      cnt_d = cnt_q + 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q <= '0;
    end else if (cnt_en) begin
      cnt_q <= cnt_d;
    end
  end

endmodule

// File: rtl/cfg_abort_filter.sv
module cfg_abort_filter #(
  parameter int ABORT_TICKS = 3
) (
  input  logic clk,
  input  logic rst_n,
  input  logic run_i,
  input  logic pin_low_i,
  input  logic tick_i,
  output logic abort_o
);

  localparam int CW = $clog2(ABORT_TICKS + 1);
  localparam logic [CW-1:0] LAST = CW'(ABORT_TICKS - 1);

  logic [CW-1:0] cnt_q;
  logic [CW-1:0] cnt_d;
  logic          cnt_en;
  logic          armed;

  always_comb begin
    armed   = run_i & pin_low_i;
    abort_o = armed & tick_i & (cnt_q == LAST);
    cnt_en  = ~armed | tick_i;
    cnt_d   = cnt_q;
    if (!armed || abort_o) begin
      cnt_d = '0;
    end else if (tick_i) begin
      cnt_d = cnt_q + 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q <= '0;
    end else if (cnt_en) begin
      cnt_q <= cnt_d;
    end
  end

endmodule

// File: rtl/cfg_startup_seq.sv
module cfg_startup_seq
  import cfg_startup_pkg::*;
#(
  parameter int CNT_W       = 14,
  parameter int MST_SHIFT   = 2,
  parameter int ABORT_TICKS = 3,
  parameter int SYNC_STAGES = 2
) (
  input  logic       clk,
  input  logic       por_n,
  input  logic       tick_i,
  input  logic       rst_pin_n_i,
  input  logic       prog_pin_i,
  input  logic [2:0] mode_pin_i,
  input  logic       clr_done_i,
  output logic [2:0] state_o,
  output logic [2:0] mode_o,
  output logic       init_low_o,
  output logic       obuf_dis_o,
  output logic       pdn_inhibit_o,
  output logic       clr_req_o
);

  localparam int NPINS   = 2;
  localparam int PIN_RST = 0;
  localparam int PIN_PRG = 1;

  seq_state_e state_q;
  seq_state_e state_d;
  logic [2:0] mode_q;
  logic       mode_ld;
  logic       prog_prev_q;

  logic [NPINS-1:0] pin_raw;
  logic [NPINS-1:0] pin_s;
  logic             rst_rel;
  logic             prog_s;
  logic             prog_fall;
  logic             init_exp;
  logic             abort_exp;

  assign pin_raw[PIN_RST] = rst_pin_n_i;
  assign pin_raw[PIN_PRG] = prog_pin_i;

  for (genvar g = 0; g < NPINS; g++) begin : g_sync
    cfg_pin_sync #(
      .STAGES  (SYNC_STAGES),
      .RST_VAL (1'b0)
    ) u_sync (
      .clk   (clk),
      .rst_n (por_n),
      .d_i   (pin_raw[g]),
      .q_o   (pin_s[g])
    );
  end

  assign rst_rel   = pin_s[PIN_RST];
  assign prog_s    = pin_s[PIN_PRG];
  assign prog_fall = prog_prev_q & ~prog_s;

  cfg_init_timer #(
    .CNT_W     (CNT_W),
    .MST_SHIFT (MST_SHIFT)
  ) u_timer (
    .clk      (clk),
    .rst_n    (por_n),
    .run_i    (state_q == ST_POWERUP),
    .tick_i   (tick_i),
    .master_i (mode_is_master(mode_pin_i)),
    .expire_o (init_exp)
  );

  cfg_abort_filter #(
    .ABORT_TICKS (ABORT_TICKS)
  ) u_abort (
    .clk       (clk),
    .rst_n     (por_n),
    .run_i     (state_q == ST_LOAD),
    .pin_low_i (~rst_rel),
    .tick_i    (tick_i),
    .abort_o   (abort_exp)
  );

  always_comb begin
    state_d = state_q;
    mode_ld = 1'b0;
    case (state_q)
      ST_POWERUP: if (init_exp) state_d = ST_ERASE;
      ST_ERASE:   if (clr_done_i) state_d = ST_ARMED;
      ST_ARMED: begin
        if (rst_rel && mode_is_legal(mode_pin_i)) begin
          state_d = ST_LOAD;
          mode_ld = 1'b1;
        end
      end
      ST_LOAD: begin
        if (abort_exp) begin
          state_d = ST_ERASE;
        end else if (prog_s) begin
          state_d = ST_RUN;
        end
      end
      ST_RUN:     if (prog_fall) state_d = ST_ERASE;
      default:    state_d = ST_POWERUP;
    endcase
  end

  always_ff @(posedge clk or negedge por_n) begin
    if (!por_n) begin
      state_q     <= ST_POWERUP;
      mode_q      <= 3'b000;
      prog_prev_q <= 1'b0;
    end else begin
      state_q     <= state_d;
      prog_prev_q <= prog_s;
      if (mode_ld) begin
        mode_q <= mode_pin_i;
      end
    end
  end

  always_comb begin
    state_o       = state_q;
    mode_o        = mode_q;
    init_low_o    = (state_q == ST_POWERUP) || (state_q == ST_ERASE);
    obuf_dis_o    = (state_q != ST_RUN);
    pdn_inhibit_o = (state_q == ST_POWERUP);
    clr_req_o     = (state_q == ST_ERASE);
  end

endmodule

// File: rtl/cfg_startup_seq_chk.sv
module cfg_startup_seq_chk (
  input logic       clk,
  input logic       por_n,
  input logic [2:0] mode_pin_i,
  input logic       clr_done_i,
  input logic [2:0] state_o,
  input logic [2:0] mode_o,
  input logic       init_low_o,
  input logic       obuf_dis_o,
  input logic       pdn_inhibit_o,
  input logic       clr_req_o
);

  assert_init_exit_R2: assert property (@(posedge clk) disable iff (!por_n)
    (state_o == 3'd0) |=> (state_o == 3'd0 || state_o == 3'd1));

  assert_pdn_scope_R4: assert property (@(posedge clk) disable iff (!por_n)
    pdn_inhibit_o |-> (obuf_dis_o && init_low_o));

  assert_erase_exit_R5: assert property (@(posedge clk) disable iff (!por_n)
    (state_o == 3'd1 && clr_done_i) |=> (state_o == 3'd2));

  assert_erase_wait_R5: assert property (@(posedge clk) disable iff (!por_n)
    (state_o == 3'd1 && !clr_done_i) |=> (state_o == 3'd1));

  assert_clr_entry_R5: assert property (@(posedge clk) disable iff (!por_n)
    $rose(clr_req_o) |-> ($past(state_o) == 3'd0 || $past(state_o) == 3'd3 ||
                          $past(state_o) == 3'd4));

  assert_init_release_R6: assert property (@(posedge clk) disable iff (!por_n)
    $fell(init_low_o) |-> (state_o == 3'd2 && $past(state_o) == 3'd1));

  assert_mode_hold_R7: assert property (@(posedge clk) disable iff (!por_n)
    (state_o != 3'd2) |=> $stable(mode_o));

  assert_mode_latch_R7: assert property (@(posedge clk) disable iff (!por_n)
    ($past(state_o) == 3'd2 && state_o == 3'd3) |-> (mode_o == $past(mode_pin_i)));

  assert_obuf_release_R9: assert property (@(posedge clk) disable iff (!por_n)
    $fell(obuf_dis_o) |-> ($past(state_o) == 3'd3));

  assert_run_exit_R10: assert property (@(posedge clk) disable iff (!por_n)
    (state_o == 3'd4) |=> (state_o == 3'd4 || state_o == 3'd1));

endmodule

bind cfg_startup_seq cfg_startup_seq_chk u_chk (
  .clk           (clk),
  .por_n         (por_n),
  .mode_pin_i    (mode_pin_i),
  .clr_done_i    (clr_done_i),
  .state_o       (state_o),
  .mode_o        (mode_o),
  .init_low_o    (init_low_o),
  .obuf_dis_o    (obuf_dis_o),
  .pdn_inhibit_o (pdn_inhibit_o),
  .clr_req_o     (clr_req_o)
);

// File: tb/tb_cfg_startup_seq.sv
module tb_cfg_startup_seq;

  localparam int CNT_W = 4;
  localparam int BASE  = 16;
  localparam int MLIM  = 64;

  logic       clk;
  logic       por_n;
  logic       tick_i;
  logic       rst_pin_n_i;
  logic       prog_pin_i;
  logic [2:0] mode_pin_i;
  logic       clr_done_i;
  logic [2:0] state_o;
  logic [2:0] mode_o;
  logic       init_low_o;
  logic       obuf_dis_o;
  logic       pdn_inhibit_o;
  logic       clr_req_o;

  int n_chk;
  int n_err;
  int cyc;
  bit fin;

  cfg_startup_seq #(.CNT_W(CNT_W)) dut (
    .clk           (clk),
    .por_n         (por_n),
    .tick_i        (tick_i),
    .rst_pin_n_i   (rst_pin_n_i),
    .prog_pin_i    (prog_pin_i),
    .mode_pin_i    (mode_pin_i),
    .clr_done_i    (clr_done_i),
    .state_o       (state_o),
    .mode_o        (mode_o),
    .init_low_o    (init_low_o),
    .obuf_dis_o    (obuf_dis_o),
    .pdn_inhibit_o (pdn_inhibit_o),
    .clr_req_o     (clr_req_o)
  );

  initial clk = 1'b0;
  always #2.5ns clk = ~clk;

  task automatic chk(input string tag, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_err++;
      $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
    end
  endtask

  function automatic bit is_mst(input logic [2:0] c);
    return (c == 3'b000) || (c == 3'b010) || (c == 3'b011);
  endfunction

  function automatic bit is_ok(input logic [2:0] c);
    return is_mst(c) || (c == 3'b101) || (c == 3'b111);
  endfunction

  // behavioural reference model
  int         m_st;
  logic [2:0] m_mode;
  int         m_icnt;
  int         m_dcnt;
  int         m_lim;
  logic       r1, r2, p1, p2, pp;

  always @(posedge clk or negedge por_n) begin
    if (!por_n) begin
      m_st = 0; m_mode = 3'b000; m_icnt = 0; m_dcnt = 0;
      r1 = 0; r2 = 0; p1 = 0; p2 = 0; pp = 0;
    end else begin
      m_lim = is_mst(mode_pin_i) ? MLIM : BASE;
      case (m_st)
        0: if (tick_i) begin
             if (m_icnt + 1 >= m_lim) m_st = 1;
             else m_icnt++;
           end
        1: if (clr_done_i) m_st = 2;
        2: if (r2 && is_ok(mode_pin_i)) begin m_mode = mode_pin_i; m_st = 3; end
        3: begin
             if (!r2 && tick_i && m_dcnt + 1 >= 3) begin
               m_st = 1;
             end else begin
               if (r2) m_dcnt = 0;
               else if (tick_i) m_dcnt++;
               if (p2) m_st = 4;
             end
           end
        4: if (pp && !p2) m_st = 1;
        default: m_st = 0;
      endcase
      if (m_st != 3) m_dcnt = 0;
      pp = p2; p2 = p1; p1 = prog_pin_i;
      r2 = r1; r1 = rst_pin_n_i;
    end
  end

  always @(negedge clk) begin
    if (por_n && !fin) begin
      chk("R11 state vs model", int'(state_o), m_st);
      chk("R7 mode_o vs model", int'(mode_o), int'(m_mode));
      chk("R6 init_low vs model", int'(init_low_o), int'(m_st <= 1));
      chk("R9 obuf_dis vs model", int'(obuf_dis_o), int'(m_st != 4));
      chk("R4 pdn_inhibit vs model", int'(pdn_inhibit_o), int'(m_st == 0));
      chk("R5 clr_req vs model", int'(clr_req_o), int'(m_st == 1));
    end
  end

  always @(posedge clk) begin
    cyc++;
    if (cyc > 20000 && !fin) begin
      fin = 1'b1;
      n_chk++;
      n_err++;
      $display("FAIL watchdog: actual %0d cycles expected below 20000", cyc);
      $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
      $finish;
    end
  end

  task automatic pulse_tick(input int n);
    for (int i = 0; i < n; i++) begin
      tick_i = 1'b1;
      @(negedge clk);
      tick_i = 1'b0;
      @(negedge clk);
    end
  endtask

  task automatic pulse_clr();
    clr_done_i = 1'b1;
    @(negedge clk);
    clr_done_i = 1'b0;
  endtask

  initial begin
    n_chk = 0; n_err = 0; cyc = 0; fin = 1'b0;
    por_n = 1'b0; tick_i = 1'b0; rst_pin_n_i = 1'b0; prog_pin_i = 1'b0;
    mode_pin_i = 3'b111; clr_done_i = 1'b0;
    repeat (3) @(negedge clk);
    // R1 reset values
    chk("R1 state", int'(state_o), 0);
    chk("R1 mode_o", int'(mode_o), 0);
    chk("R1 init_low", int'(init_low_o), 1);
    chk("R1 obuf_dis", int'(obuf_dis_o), 1);
    chk("R1 pdn_inhibit", int'(pdn_inhibit_o), 1);
    chk("R1 clr_req", int'(clr_req_o), 0);
    por_n = 1'b1;

    // R2 slave code: base time-out
    pulse_tick(BASE - 1);
    chk("R2 still powerup", int'(state_o), 0);
    chk("R4 pdn_inhibit in powerup", int'(pdn_inhibit_o), 1);
    pulse_tick(1);
    chk("R2 erase after base ticks", int'(state_o), 1);
    chk("R5 clr_req", int'(clr_req_o), 1);
    chk("R6 init_low in erase", int'(init_low_o), 1);
    chk("R4 pdn_inhibit off", int'(pdn_inhibit_o), 0);
    repeat (5) @(negedge clk);
    chk("R5 erase waits", int'(state_o), 1);
    pulse_clr();
    chk("R5 armed after clr_done", int'(state_o), 2);
    chk("R6 init released", int'(init_low_o), 0);

    // R7 reserved code stays armed
    mode_pin_i = 3'b100;
    rst_pin_n_i = 1'b1;
    repeat (6) @(negedge clk);
    chk("R7 reserved holds armed", int'(state_o), 2);
    mode_pin_i = 3'b111;
    @(negedge clk);
    chk("R7 load entered", int'(state_o), 3);
    chk("R7 mode captured", int'(mode_o), 7);

    // R8 abort debounce
    rst_pin_n_i = 1'b0;
    repeat (3) @(negedge clk);
    pulse_tick(2);
    chk("R8 two ticks no abort", int'(state_o), 3);
    rst_pin_n_i = 1'b1;
    repeat (3) @(negedge clk);
    pulse_tick(1);
    rst_pin_n_i = 1'b0;
    repeat (3) @(negedge clk);
    pulse_tick(2);
    chk("R8 count restarted", int'(state_o), 3);
    pulse_tick(1);
    chk("R8 abort to erase", int'(state_o), 1);

    // R7 resample after abort, pin latency
    pulse_clr();
    repeat (4) @(negedge clk);
    chk("R7 armed while reset low", int'(state_o), 2);
    mode_pin_i = 3'b101;
    rst_pin_n_i = 1'b1;
    repeat (2) @(negedge clk);
    chk("R7 not yet at edge two", int'(state_o), 2);
    @(negedge clk);
    chk("R7 load at edge three", int'(state_o), 3);
    chk("R7 peripheral captured", int'(mode_o), 5);

    // R9 configured
    prog_pin_i = 1'b1;
    repeat (2) @(negedge clk);
    chk("R9 still load", int'(state_o), 3);
    @(negedge clk);
    chk("R9 configured", int'(state_o), 4);
    chk("R9 obuf released", int'(obuf_dis_o), 0);

    // R10 reprogram
    prog_pin_i = 1'b0;
    repeat (2) @(negedge clk);
    chk("R10 still configured", int'(state_o), 4);
    @(negedge clk);
    chk("R10 erase on falling edge", int'(state_o), 1);
    mode_pin_i = 3'b000;
    pulse_clr();
    chk("R10 armed", int'(state_o), 2);
    @(negedge clk);
    chk("R10 reload", int'(state_o), 3);
    chk("R10 mode resampled", int'(mode_o), 0);

    // R3 master time-out
    por_n = 1'b0;
    mode_pin_i = 3'b010;
    rst_pin_n_i = 1'b0;
    repeat (2) @(negedge clk);
    chk("R1 mode_o cleared", int'(mode_o), 0);
    chk("R1 state cleared", int'(state_o), 0);
    por_n = 1'b1;
    pulse_tick(MLIM - 1);
    chk("R3 master still powerup", int'(state_o), 0);
    pulse_tick(1);
    chk("R3 master erase", int'(state_o), 1);

    repeat (2) @(negedge clk);
    fin = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
    $finish;
  end

endmodule